// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Controller

This block is the digital control core of a 128-step digitally controlled resistor. A host writes a wiper position over a three-wire serial link: a serial clock, an active-low select and a data line. Bits enter a 7-bit shift register while select is low. When select goes high, the newest seven bits become the wiper position. A decoder turns that position into one-hot tap-switch controls for the resistor ladder. A separate data output carries the bits that fall out of the shift register, so several controllers can be chained on one select and clock.

Every control input is synchronised to the system clock `clk`, and serial edges are found by oversampling. A preset input forces the wiper to midscale. A shutdown input opens terminal A, shorts the wiper to terminal B and turns off every tap and the data-output driver. The stored position is kept through shutdown, and the serial path keeps accepting new codes while shutdown is active.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: A synchronised rising edge of `ser_clk` seen while `ser_cs_n` is low shifts `ser_di` into the shift register. Rising edges of `ser_clk` seen while `ser_cs_n` is high leave the shift register unchanged.
- R2: A synchronised rising edge of `ser_cs_n` copies the shift register to `code`, so only the last seven bits of a longer frame are kept. `code` changes at no other time, apart from a preset or a system reset.
- R3: The serial output bit is registered. After the n-th shifting edge of a frame it holds bit n-6 of that frame. In a chain of two controllers, a 14-bit frame puts its first seven bits in the far controller and its last seven bits in the near one.
- R4: While `preset_n` (synchronised) is low, `code` is loaded with 64 (7'h40) and the serial output bit is cleared, which makes `sdo_pull_low` 1. Preset takes priority over a select rising edge that arrives in the same cycle.
- R5: While `shdn_n` (synchronised) is low, `term_a_open` and `wiper_b_short` are 1 and `tap_sel` is all zeros. `code` keeps its value.
- R6: The serial path stays active during shutdown. A code committed during shutdown appears on `tap_sel` as soon as shutdown is released.
- R7: During shutdown `sdo_pull_low` is 0, so the output line floats high. Outside shutdown, `sdo_pull_low` is the inverse of the serial output bit.
- R8: Outside shutdown, `tap_sel` has exactly one bit set, bit index = `code`. Bit 0 is the tap at terminal B and bit 127 is the last tap, one step below terminal A.
- R9: Each input passes through two synchroniser flops. A serial-clock or select edge takes effect at the third `clk` rising edge after it is first sampled. A shutdown change reaches the outputs after the second `clk` rising edge.
- R10: A synchronous system reset (`rst_n` low) sets `code` to 64 and clears both the shift register and the serial output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Synchronous active-low system reset |
| preset_n | input | 1 | Asynchronous active-low request to move the wiper to midscale |
| shdn_n | input | 1 | Asynchronous active-low shutdown request |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_cs_n | input | 1 | Active-low serial select; its rising edge commits the code |
| ser_di | input | 1 | Serial data input |
| code | output | 7 | Committed wiper position |
| tap_sel | output | 128 | One-hot tap switch controls; bit 0 is at terminal B |
| term_a_open | output | 1 | Disconnects terminal A (shutdown) |
| wiper_b_short | output | 1 | Shorts the wiper to terminal B (shutdown) |
| sdo_pull_low | output | 1 | Pull-down enable of the open-drain serial output |

## Verification
The assertions assume that every serial-clock and select level lasts at least two `clk` periods, so the synchroniser misses no edge. They also assume that `ser_di` is steady across the sample in which a serial-clock rise is seen, and that a serial-clock rise and a select rise are never detected in the same cycle. The bench holds each serial phase for three system clocks and changes data only when the serial clock falls. It raises select only after the serial clock has been low for several cycles. The single exception is the preset test, which deliberately lines up a preset with a select rise to exercise the priority.

// File: rtl/wpc_pkg.sv
// Package: shared constants and helpers for the wiper position controller.
// Assumes: positions are unsigned binary, midscale is the MSB alone.
package wpc_pkg;

    // Midscale code for a given position width (MSB set, rest clear).
    function automatic logic [15:0] midscale(input int width);
        logic [15:0] v;
        v = '0;
        v[width-1] = 1'b1;
        return v;
    endfunction

    // Bit order of the synchronised control vector.
    localparam int SIG_DI    = 0;
    localparam int SIG_SCLK  = 1;
    localparam int SIG_CS    = 2;
    localparam int SIG_SHDN  = 3;
    localparam int SIG_PRE   = 4;
    localparam int SIG_COUNT = 5;

endpackage

// File: rtl/wpc_sync.sv
// Module: multi-bit synchroniser, STAGES flops per bit, for level signals.
// Assumes: each bit is an independent slow level; no bus coherency required.
module wpc_sync #(
    parameter int WIDTH = 5,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/wpc_serial.sv
// Module: serial front end. Detects serial-clock and select edges on
// synchronised levels, shifts data, commits the position on select rise,
// and holds the registered serial output bit.
// Assumes: inputs are already synchronised to clk; serial phases last at
// least two clk periods.
module wpc_serial
    import wpc_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              di_s,
    input  logic              preset_n_s,
    output logic [CODE_W-1:0] code,
    output logic              sdo_bit,
    output logic              load_ev,
    output logic              preset_act
);

    localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

    logic              sclk_prev;
    logic              cs_prev;
    logic              shift_en;
    logic [CODE_W-1:0] shreg;
    logic [CODE_W-1:0] shreg_nxt;

    assign shift_en   = sclk_s & ~sclk_prev & ~cs_n_s;
    assign load_ev    = cs_n_s & ~cs_prev;
    assign preset_act = ~preset_n_s;
    assign shreg_nxt  = {shreg[CODE_W-2:0], di_s};

    // Purpose: remember last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            cs_prev   <= cs_n_s;
        end
    end

    // Purpose: serial-to-parallel shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= shreg_nxt;
    end

    // Purpose: registered serial output bit, cleared by preset.
    always_ff @(posedge clk) begin
        if (!rst_n)          sdo_bit <= 1'b0;
        else if (preset_act) sdo_bit <= 1'b0;
        else if (shift_en)   sdo_bit <= shreg_nxt[CODE_W-1];
    end

    // Purpose: position latch; preset wins over a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)          code <= MID;
        else if (preset_act) code <= MID;
        else if (load_ev)    code <= shreg;
    end

    assert_noshift_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && sclk_s && !sclk_prev) |=> $stable(shreg));

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_ev && !preset_act) |=> $stable(code));

    assert_sdo_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !preset_act) |=> (sdo_bit == $past(shreg[CODE_W-2])));

    assert_preset_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preset_act |=> (code == MID && !sdo_bit));

endmodule

// File: rtl/wpc_tap_decode.sv
// Module: position-to-tap decoder producing one-hot switch controls.
// Assumes: enable low (shutdown) must turn every tap off.
module wpc_tap_decode #(
    parameter int CODE_W = 7,
    localparam int TAPS = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              enable,
    output logic [TAPS-1:0]   tap_sel
);

    // Purpose: one comparator per tap, bit 0 nearest terminal B.
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tap_sel[g] = enable & (code == CODE_W'(g));
    end

endmodule

// File: rtl/wiper_pos_ctrl.sv
// Module: top of the serial-loaded wiper position controller.
// Synchronises all control inputs, runs the serial front end, decodes the
// tap select and drives the shutdown and open-drain output controls.
// Assumes: one system clock oversampling the serial link.
module wiper_pos_ctrl
    import wpc_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int SYNC_STAGES = 2,
    localparam int TAPS = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_n,
    input  logic              shdn_n,
    input  logic              ser_clk,
    input  logic              ser_cs_n,
    input  logic              ser_di,
    output logic [CODE_W-1:0] code,
    output logic [TAPS-1:0]   tap_sel,
    output logic              term_a_open,
    output logic              wiper_b_short,
    output logic              sdo_pull_low
);

    localparam logic [SIG_COUNT-1:0] SYNC_IDLE = 5'b11100;

    logic [SIG_COUNT-1:0] raw_vec;
    logic [SIG_COUNT-1:0] syn_vec;
    logic                 shdn_act;
    logic                 sdo_bit;
    logic                 load_ev;
    logic                 preset_act;

    assign raw_vec[SIG_DI]   = ser_di;
    assign raw_vec[SIG_SCLK] = ser_clk;
    assign raw_vec[SIG_CS]   = ser_cs_n;
    assign raw_vec[SIG_SHDN] = shdn_n;
    assign raw_vec[SIG_PRE]  = preset_n;

    wpc_sync #(
        .WIDTH  (SIG_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (raw_vec),
        .q_out(syn_vec)
    );

    wpc_serial #(.CODE_W(CODE_W)) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (syn_vec[SIG_SCLK]),
        .cs_n_s    (syn_vec[SIG_CS]),
        .di_s      (syn_vec[SIG_DI]),
        .preset_n_s(syn_vec[SIG_PRE]),
        .code      (code),
        .sdo_bit   (sdo_bit),
        .load_ev   (load_ev),
        .preset_act(preset_act)
    );

    assign shdn_act = ~syn_vec[SIG_SHDN];

    wpc_tap_decode #(.CODE_W(CODE_W)) u_decode (
        .code   (code),
        .enable (~shdn_act),
        .tap_sel(tap_sel)
    );

    // Purpose: shutdown switch controls and open-drain pull-down enable.
    always_comb begin
        term_a_open   = shdn_act;
        wiper_b_short = shdn_act;
        sdo_pull_low  = ~shdn_act & ~sdo_bit;
    end

    assert_shdn_code_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_act && !load_ev && !preset_act) |=> $stable(code));

    assert_release_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdn_act) |-> tap_sel[code]);

endmodule

// File: tb/wiper_pos_ctrl_tb.sv
module wiper_pos_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         preset_n = 1'b1;
    logic         shdn_n = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_cs_n = 1'b1;
    logic         ser_di = 1'b0;
    logic [6:0]   code, code2;
    logic [127:0] tap_sel, tap_sel2;
    logic         a_open, b_short, pull_low;
    logic         a_open2, b_short2, pull_low2;
    logic         chain_line;

    int n_tests = 0;
    int n_fail = 0;
    bit model_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wiper_pos_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .shdn_n(shdn_n),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_di(ser_di),
        .code(code), .tap_sel(tap_sel), .term_a_open(a_open),
        .wiper_b_short(b_short), .sdo_pull_low(pull_low)
    );

    // open-drain line with pull-up feeding the second controller
    assign chain_line = ~pull_low;

    wiper_pos_ctrl u_dut2 (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .shdn_n(shdn_n),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_di(chain_line),
        .code(code2), .tap_sel(tap_sel2), .term_a_open(a_open2),
        .wiper_b_short(b_short2), .sdo_pull_low(pull_low2)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference: histories of raw inputs, R9 latency
    logic [3:0] h_sclk, h_cs, h_pre, h_sh, h_di;
    logic [6:0] m_code, m_sreg, m_old;
    logic       m_sdo;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_sclk = 4'h0; h_cs = 4'hF; h_pre = 4'hF; h_sh = 4'hF; h_di = 4'h0;
            m_code = 7'd64; m_sreg = 7'd0; m_sdo = 1'b0;
        end else begin
            h_sclk = {h_sclk[2:0], ser_clk};
            h_cs   = {h_cs[2:0], ser_cs_n};
            h_pre  = {h_pre[2:0], preset_n};
            h_sh   = {h_sh[2:0], shdn_n};
            h_di   = {h_di[2:0], ser_di};
            m_old  = m_sreg;
            if (h_sclk[2] && !h_sclk[3] && !h_cs[2]) begin
                m_sreg = {m_sreg[5:0], h_di[2]};
                m_sdo  = m_sreg[6];
            end
            if (!h_pre[2]) begin
                m_code = 7'd64;
                m_sdo  = 1'b0;
            end else if (h_cs[2] && !h_cs[3]) begin
                m_code = m_old;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            automatic logic sd = !h_sh[1];
            chk("R9 model code", 128'(code), 128'(m_code));
            chk("R8 model tap", tap_sel, sd ? 128'd0 : (128'd1 << m_code));
            chk("R7 model flags", {125'd0, a_open, b_short, pull_low},
                {125'd0, sd, sd, !sd && !m_sdo});
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [15:0] bits);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_clk = 1'b0;
            ser_di  = bits[i];
            wait_cyc(3);
            ser_clk = 1'b1;
            wait_cyc(3);
        end
        @(negedge clk);
        ser_clk = 1'b0;
        wait_cyc(3);
    endtask

    task automatic frame(input int n, input logic [15:0] bits);
        @(negedge clk);
        ser_cs_n = 1'b0;
        wait_cyc(3);
        send_bits(n, bits);
        @(negedge clk);
        ser_cs_n = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        model_on = 1;
        // R10 reset state
        chk("R10 reset code", 128'(code), 128'd64);
        chk("R10 reset sdo cleared", 128'(pull_low), 128'd1);
        chk("R8 reset tap midscale", tap_sel, 128'd1 << 64);

        // R2 seven-bit load
        frame(7, 16'h002B);
        chk("R2 7-bit load", 128'(code), 128'h2B);
        chk("R8 tap one-hot", tap_sel, 128'd1 << 7'h2B);

        // R2 nine-bit load keeps last seven; R3 output bit = bit 3 = 1
        frame(9, {7'd0, 2'b10, 7'h55});
        chk("R2 9-bit load", 128'(code), 128'h55);
        chk("R3 sdo after 9 edges", 128'(pull_low), 128'd0);

        // R8 boundary codes
        frame(7, 16'h0000);
        chk("R8 code 0 tap at B", tap_sel, 128'd1);
        frame(7, 16'h007F);
        chk("R8 code 127 last tap", tap_sel, 128'd1 << 127);

        // R1 clocks with select high do not shift
        frame(7, 16'h0031);
        send_bits(4, 16'h000F);
        frame(0, 16'h0000);
        chk("R1 no shift when deselected", 128'(code), 128'h31);

        // R9 latency of a commit
        @(negedge clk); ser_cs_n = 1'b0; wait_cyc(3);
        send_bits(7, 16'h003C);
        @(negedge clk); ser_cs_n = 1'b1;
        wait_cyc(2);
        chk("R9 commit not before third edge", 128'(code), 128'h31);
        wait_cyc(1);
        chk("R9 commit at third edge", 128'(code), 128'h3C);
        wait_cyc(4);

        // R3 two-device chain, 14 bits
        frame(14, {2'b00, 7'h11, 7'h6E});
        chk("R3 chain near device", 128'(code), 128'h6E);
        chk("R3 chain far device", 128'(code2), 128'h11);

        // R5/R7 shutdown
        @(negedge clk); shdn_n = 1'b0;
        wait_cyc(2);
        chk("R5 shutdown tap off", tap_sel, 128'd0);
        chk("R5 shutdown switches", {126'd0, a_open, b_short}, 128'd3);
        chk("R5 code kept", 128'(code), 128'h6E);
        chk("R7 sdo released", 128'(pull_low), 128'd0);
        // R6 load during shutdown
        frame(7, 16'h000F);
        chk("R6 code loads in shutdown", 128'(code), 128'h0F);
        chk("R6 tap still off", tap_sel, 128'd0);
        @(negedge clk); shdn_n = 1'b1;
        wait_cyc(2);
        chk("R6 new code on release", tap_sel, 128'd1 << 15);
        chk("R5 switches released", {126'd0, a_open, b_short}, 128'd0);

        // R4 preset during idle clears sdo bit
        frame(7, 16'h007F);
        chk("R4 sdo set before preset", 128'(pull_low), 128'd0);
        @(negedge clk); preset_n = 1'b0;
        wait_cyc(4);
        preset_n = 1'b1;
        wait_cyc(4);
        chk("R4 preset midscale", 128'(code), 128'd64);
        chk("R4 preset clears sdo", 128'(pull_low), 128'd1);

        // R4 preset beats a simultaneous select rise
        @(negedge clk); ser_cs_n = 1'b0; wait_cyc(3);
        send_bits(7, 16'h0005);
        @(negedge clk); ser_cs_n = 1'b1; preset_n = 1'b0;
        wait_cyc(4);
        preset_n = 1'b1;
        wait_cyc(4);
        chk("R4 preset priority", 128'(code), 128'd64);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule